// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block lays a 64x64 pixel cursor over a 24-bit pixel stream on its way from the display pipeline to the output stage. The cursor image uses two bits per pixel. Each code selects one of four looks: the first cursor colour, the second cursor colour, the untouched screen pixel, or the screen pixel with every bit inverted. Register-style inputs set the cursor position, the hot-spot offsets, both colours, an enable, and the interlace controls.

Pattern data sits in a cursor memory region. The block reads it through a simple read port whose latency is a fixed number of cycles. At the start of each horizontal sync the block decides whether the coming line crosses the cursor box. If it does, the block reads that cursor row's 16 bytes into a small line buffer. The active region then reads only from this buffer and never from memory.

The pixel output and the data-enable, horizontal sync and vertical sync outputs are all registered. Each one follows its input by exactly one cycle.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is high, and on the first sampled cycle, `out_pixel`, `out_de`, `out_hsync`, `out_vsync` and `mem_req` are all zero.
- R2: `out_de`, `out_hsync` and `out_vsync` equal `in_de`, `in_hsync` and `in_vsync` of the previous cycle.
- R3: `out_pixel` is the result for the previous cycle's inputs. Inside the cursor box, code 0 gives `color0`, code 1 gives `color1`, code 2 gives `in_pixel`, and code 3 gives `in_pixel` with all 24 bits inverted.
- R4: For a pixel at box column c (0..63) of box row r, the pattern byte is at address r*16 + c/4. Its code is bits [2*(c%4)+1 : 2*(c%4)]. The lowest bit pair is therefore the leftmost pixel.
- R5: The left edge of the box is column `cur_x - hot_x`, which may be negative. Pixels whose column offset from that edge lies outside 0..63 output `in_pixel` unchanged.
- R6: Without interlace, the top edge of the box is line `cur_y - hot_y`. Box row r = `next_line` - top, and only rows 0..63 are drawn.
- R7: On each rising edge of `in_hsync` that selects a drawn row r, `mem_req` is high for 16 consecutive cycles. The addresses run r*16 through r*16+15 in order, and each read takes its data from `mem_rdata` RD_LAT cycles after the request. `mem_req` is never high while `in_de` is high.
- R8: When `cur_en` is low, no memory read is issued and every output pixel equals the previous cycle's `in_pixel`.
- R9: With `interlace` high, the line is frame line 2*`next_line` + `field_odd`. The top edge is frame line 2*`cur_y` + `odd_start` - `hot_y`, and the row is the difference between the two.
- R10: In a cycle where `in_de` is low, `in_pixel` passes through unchanged, even when `pix_x` falls inside the box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_en | input | 1 | Cursor enable |
| interlace | input | 1 | Interlaced operation |
| odd_start | input | 1 | In interlaced mode, cursor starts on an odd frame line |
| cur_x | input | 11 | Cursor X position (pixels) |
| cur_y | input | 11 | Cursor Y position (lines; half lines when interlaced) |
| hot_x | input | 5 | Hot-spot X offset |
| hot_y | input | 5 | Hot-spot Y offset |
| color0 | input | 24 | Cursor colour for code 0 |
| color1 | input | 24 | Cursor colour for code 1 |
| next_line | input | 11 | Line number of the active region that follows this horizontal sync |
| field_odd | input | 1 | Current field is the odd field |
| pix_x | input | 11 | Column of the current pixel |
| in_de | input | 1 | Data enable of the incoming stream |
| in_hsync | input | 1 | Horizontal sync of the incoming stream |
| in_vsync | input | 1 | Vertical sync of the incoming stream |
| in_pixel | input | 24 | Incoming screen pixel |
| mem_req | output | 1 | Cursor memory read strobe |
| mem_addr | output | 10 | Cursor memory byte address |
| mem_rdata | input | 8 | Read data, valid RD_LAT cycles after the request |
| out_pixel | output | 24 | Pixel with the cursor laid over it |
| out_de | output | 1 | Delayed data enable |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |

## Verification
The bench places the box so that the hot-spot pushes its corner past the top and left screen edges. A design that used a plain unsigned subtraction would lose the clipped rows and columns or wrap them onto the far side. Other cases place the box across the right end of the active line, and put box rows 63 and 64 next to each other, where an off-by-one bound shows up as one stray or missing row. In interlaced runs both fields and both start parities are covered, so a design that dropped the field bit or the odd-start flag draws the cursor one frame line off. Each byte holds a different mix of codes, so a reversed pixel order inside a byte or an error in the read latency changes pixel colours at once. Blank cycles are driven with `pix_x` inside the box, which catches a design that overlays the cursor outside the active region.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  // Two-bit cursor pixel codes
  typedef enum logic [1:0] {
    CODE_COLOR0 = 2'd0,
    CODE_COLOR1 = 2'd1,
    CODE_SCREEN = 2'd2,
    CODE_INVERT = 2'd3
  } cur_code_e;

  localparam int CODE_W       = 2;
  localparam int BYTE_W       = 8;
  localparam int PIX_PER_BYTE = BYTE_W / CODE_W;

  // Pick the code of one pixel slot in a pattern byte; slot 0 is the low pair
  function automatic cur_code_e pick_code(input logic [BYTE_W-1:0] b,
                                          input logic [1:0] slot);
    return cur_code_e'(b[slot*CODE_W +: CODE_W]);
  endfunction

endpackage

// File: rtl/cursor_linebuf.sv
module cursor_linebuf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch #(
  parameter int POS_W  = 11,
  parameter int HOT_W  = 5,
  parameter int ROW_W  = 6,
  parameter int BIDX_W = 4,
  parameter int DW     = 8,
  parameter int RD_LAT = 2,
  localparam int ADDR_W = ROW_W + BIDX_W,
  localparam int LINE_W = POS_W + 1,
  localparam int DIFF_W = POS_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_en,
  input  logic              interlace,
  input  logic              odd_start,
  input  logic [POS_W-1:0]  cur_y,
  input  logic [HOT_W-1:0]  hot_y,
  input  logic [POS_W-1:0]  next_line,
  input  logic              field_odd,
  input  logic              in_hsync,
  input  logic              in_de,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              wr_en,
  output logic [BIDX_W-1:0] wr_idx,
  output logic [DW-1:0]     wr_data,
  output logic              line_valid
);

  localparam logic [BIDX_W-1:0] LAST_IDX = '1;

  logic [LINE_W-1:0] frame_line, top_base;
  logic [DIFF_W-1:0] row_diff;
  logic              row_hit, hs_q, hs_rise, busy;
  logic [BIDX_W-1:0] cnt;
  logic [ROW_W-1:0]  row_q;
  logic              vld_sr [RD_LAT];
  logic [BIDX_W-1:0] idx_sr [RD_LAT];

  // Signed row offset of the coming line inside the cursor box
  assign frame_line = interlace ? {next_line, field_odd} : {1'b0, next_line};
  assign top_base   = interlace ? {cur_y, odd_start}     : {1'b0, cur_y};
  assign row_diff   = DIFF_W'(frame_line) - DIFF_W'(top_base) + DIFF_W'(hot_y);
  assign row_hit    = (row_diff[DIFF_W-1:ROW_W] == '0);
  assign hs_rise    = in_hsync & ~hs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q       <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      row_q      <= '0;
      line_valid <= 1'b0;
      for (int i = 0; i < RD_LAT; i++) begin
        vld_sr[i] <= 1'b0;
        idx_sr[i] <= '0;
      end
    end else begin
      hs_q      <= in_hsync;
      vld_sr[0] <= busy;
      idx_sr[0] <= cnt;
      for (int i = 1; i < RD_LAT; i++) begin
        vld_sr[i] <= vld_sr[i-1];
        idx_sr[i] <= idx_sr[i-1];
      end
      if (vld_sr[RD_LAT-1] && idx_sr[RD_LAT-1] == LAST_IDX) line_valid <= 1'b1;
      if (hs_rise) begin
        line_valid <= 1'b0;
        busy       <= row_hit & cur_en;
        cnt        <= '0;
        row_q      <= row_diff[ROW_W-1:0];
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST_IDX) busy <= 1'b0;
      end
    end
  end

  assign mem_req  = busy;
  assign mem_addr = {row_q, cnt};
  assign wr_en    = vld_sr[RD_LAT-1];
  assign wr_idx   = idx_sr[RD_LAT-1];
  assign wr_data  = mem_rdata;

  // R7: pattern reads stay out of the active region
  assert_fetch_blank_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !in_de);

  // R4/R7: consecutive reads walk one row's bytes in order
  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req && $past(mem_req) && !$past(hs_rise) |->
      mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  // R8: a disabled cursor issues no read
  assert_no_fetch_off_R8: assert property (@(posedge clk) disable iff (rst)
    hs_rise && !cur_en |=> !mem_req);

endmodule

// File: rtl/cursor_pixel_mux.sv
module cursor_pixel_mux
  import cursor_pkg::*;
#(
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COLOR_W-1:0] in_pixel,
  input  logic               in_de,
  input  logic               in_hsync,
  input  logic               in_vsync,
  input  logic               hit,
  input  cur_code_e          code,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  output logic [COLOR_W-1:0] out_pixel,
  output logic               out_de,
  output logic               out_hsync,
  output logic               out_vsync
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pixel <= '0;
      out_de    <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
    end else begin
      out_de    <= in_de;
      out_hsync <= in_hsync;
      out_vsync <= in_vsync;
      if (!hit) begin
        out_pixel <= in_pixel;
      end else begin
        case (code)
          CODE_COLOR0: out_pixel <= color0;
          CODE_COLOR1: out_pixel <= color1;
          CODE_INVERT: out_pixel <= ~in_pixel;
          default:     out_pixel <= in_pixel;
        endcase
      end
    end
  end

  // R5: no hit means the screen pixel goes through
  assert_pass_outside_R5: assert property (@(posedge clk) disable iff (rst)
    !hit |=> out_pixel == $past(in_pixel));

  // R3: colour codes and inversion
  assert_color0_R3: assert property (@(posedge clk) disable iff (rst)
    hit && code == CODE_COLOR0 |=> out_pixel == $past(color0));

  assert_color1_R3: assert property (@(posedge clk) disable iff (rst)
    hit && code == CODE_COLOR1 |=> out_pixel == $past(color1));

  assert_invert_R3: assert property (@(posedge clk) disable iff (rst)
    hit && code == CODE_INVERT |=> out_pixel == ~$past(in_pixel));

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int POS_W   = 11,
  parameter int HOT_W   = 5,
  parameter int COLOR_W = 24,
  parameter int CUR_DIM = 64,
  parameter int RD_LAT  = 2,
  localparam int IDX_W  = $clog2(CUR_DIM),
  localparam int NBYTES = CUR_DIM / PIX_PER_BYTE,
  localparam int BIDX_W = $clog2(NBYTES),
  localparam int ADDR_W = IDX_W + BIDX_W,
  localparam int XD_W   = POS_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cur_en,
  input  logic               interlace,
  input  logic               odd_start,
  input  logic [POS_W-1:0]   cur_x,
  input  logic [POS_W-1:0]   cur_y,
  input  logic [HOT_W-1:0]   hot_x,
  input  logic [HOT_W-1:0]   hot_y,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  input  logic [POS_W-1:0]   next_line,
  input  logic               field_odd,
  input  logic [POS_W-1:0]   pix_x,
  input  logic               in_de,
  input  logic               in_hsync,
  input  logic               in_vsync,
  input  logic [COLOR_W-1:0] in_pixel,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic [COLOR_W-1:0] out_pixel,
  output logic               out_de,
  output logic               out_hsync,
  output logic               out_vsync
);

  logic              wr_en, line_valid, x_hit, hit;
  logic [BIDX_W-1:0] wr_idx;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [XD_W-1:0]   col_diff;
  cur_code_e         code;

  cursor_fetch #(
    .POS_W(POS_W), .HOT_W(HOT_W), .ROW_W(IDX_W), .BIDX_W(BIDX_W),
    .DW(BYTE_W), .RD_LAT(RD_LAT)
  ) u_fetch (
    .clk(clk), .rst(rst), .cur_en(cur_en), .interlace(interlace),
    .odd_start(odd_start), .cur_y(cur_y), .hot_y(hot_y),
    .next_line(next_line), .field_odd(field_odd), .in_hsync(in_hsync),
    .in_de(in_de), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .line_valid(line_valid)
  );

  // Column offset from the (possibly negative) left edge of the box
  assign col_diff = XD_W'(pix_x) - XD_W'(cur_x) + XD_W'(hot_x);
  assign x_hit    = (col_diff[XD_W-1:IDX_W] == '0);

  cursor_linebuf #(.DEPTH(NBYTES), .AW(BIDX_W), .DW(BYTE_W)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .raddr(col_diff[IDX_W-1:2]), .rdata(rd_byte)
  );

  assign code = pick_code(rd_byte, col_diff[1:0]);
  assign hit  = cur_en & line_valid & in_de & x_hit;

  cursor_pixel_mux #(.COLOR_W(COLOR_W)) u_mux (
    .clk(clk), .rst(rst), .in_pixel(in_pixel), .in_de(in_de),
    .in_hsync(in_hsync), .in_vsync(in_vsync), .hit(hit), .code(code),
    .color0(color0), .color1(color1), .out_pixel(out_pixel),
    .out_de(out_de), .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  // R10: blank cycles pass the screen pixel
  assert_blank_pass_R10: assert property (@(posedge clk) disable iff (rst)
    !in_de |=> out_pixel == $past(in_pixel));

  // R8: disabled cursor leaves the stream alone
  assert_disabled_pass_R8: assert property (@(posedge clk) disable iff (rst)
    !cur_en |=> out_pixel == $past(in_pixel));

endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;

  localparam int RD_LAT = 2;
  localparam int ACT_W  = 100;
  localparam int HS_LEN = 4;
  localparam int BL_LEN = 26;

  logic        clk = 1'b0;
  logic        rst;
  logic        cur_en, interlace, odd_start, field_odd;
  logic [10:0] cur_x, cur_y, next_line, pix_x;
  logic [4:0]  hot_x, hot_y;
  logic [23:0] color0, color1, in_pixel, out_pixel;
  logic        in_de, in_hsync, in_vsync, out_de, out_hsync, out_vsync;
  logic        mem_req;
  logic [9:0]  mem_addr;
  logic [7:0]  mem_rdata, pipe0, pipe1;

  int checks = 0, fails = 0;
  int req_cnt, addr_err, exp_base, seed = 1;

  always #4 clk = ~clk;

  cursor_overlay #(.RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst(rst), .cur_en(cur_en), .interlace(interlace),
    .odd_start(odd_start), .cur_x(cur_x), .cur_y(cur_y), .hot_x(hot_x),
    .hot_y(hot_y), .color0(color0), .color1(color1), .next_line(next_line),
    .field_odd(field_odd), .pix_x(pix_x), .in_de(in_de), .in_hsync(in_hsync),
    .in_vsync(in_vsync), .in_pixel(in_pixel), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .out_pixel(out_pixel),
    .out_de(out_de), .out_hsync(out_hsync), .out_vsync(out_vsync)
  );

  function automatic logic [7:0] patt(input int a);
    int v;
    v = (a * 29 + 7) ^ (a >> 3);
    return v[7:0];
  endfunction

  // Cursor memory model: two-cycle read latency
  always @(posedge clk) begin
    pipe0 <= patt(int'(mem_addr));
    pipe1 <= pipe0;
  end
  assign mem_rdata = pipe1;

  always @(posedge clk) begin
    if (!rst && mem_req) begin
      if (int'(mem_addr) != exp_base + req_cnt) addr_err++;
      req_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_row(input int line, input int fld);
    int fl, top, r;
    fl  = interlace ? 2 * line + fld : line;
    top = interlace ? 2 * int'(cur_y) + int'(odd_start) - int'(hot_y)
                    : int'(cur_y) - int'(hot_y);
    r   = fl - top;
    return (cur_en && r >= 0 && r < 64) ? r : -1;
  endfunction

  // Expected output pixel for one input cycle (R3, R4, R5, R8, R9, R10)
  function automatic logic [23:0] exp_pix(input int row, input int x,
                                          input bit de, input logic [23:0] p,
                                          output string tag);
    int col;
    logic [7:0] b;
    int code;
    if (!de) begin tag = "R10"; return p; end
    if (!cur_en) begin tag = "R8"; return p; end
    if (row < 0) begin tag = interlace ? "R9" : "R6"; return p; end
    col = x - (int'(cur_x) - int'(hot_x));
    if (col < 0 || col > 63) begin tag = "R5"; return p; end
    tag  = interlace ? "R9" : "R3/R4";
    b    = patt(row * 16 + col / 4);
    code = (int'(b) >> (2 * (col % 4))) & 3;
    case (code)
      0:       return color0;
      1:       return color1;
      2:       return p;
      default: return ~p;
    endcase
  endfunction

  task automatic cycle(input bit de, input bit hs, input bit vs, input int x,
                       input int row);
    logic [23:0] exp;
    string tag;
    in_de    = de;
    in_hsync = hs;
    in_vsync = vs;
    pix_x    = 11'(x);
    seed     = seed * 1103515245 + 12345;
    in_pixel = 24'(seed >>> 5);
    exp      = exp_pix(row, x, de, in_pixel, tag);
    @(negedge clk);
    chk(out_pixel == exp, tag, "out_pixel", int'(out_pixel), int'(exp));
    chk({out_de, out_hsync, out_vsync} == {de, hs, vs}, "R2", "de/hs/vs",
        int'({out_de, out_hsync, out_vsync}), int'({de, hs, vs}));
  endtask

  task automatic run_line(input int line, input bit fld, input bit vs);
    int row;
    next_line = 11'(line);
    field_odd = fld;
    row       = exp_row(line, fld);
    exp_base  = row * 16;
    req_cnt   = 0;
    addr_err  = 0;
    for (int i = 0; i < HS_LEN; i++) cycle(1'b0, 1'b1, vs, 0, row);
    for (int i = 0; i < BL_LEN; i++) cycle(1'b0, 1'b0, vs, 0, row);
    chk(req_cnt == (row >= 0 ? 16 : 0), row >= 0 ? "R7" : "R8", "read count",
        req_cnt, row >= 0 ? 16 : 0);
    chk(addr_err == 0, "R7", "read addresses", addr_err, 0);
    for (int x = 0; x < ACT_W; x++) cycle(1'b1, 1'b0, vs, x, row);
  endtask

  task automatic set_cfg(input bit en, input bit il, input bit odd,
                         input int cx, input int cy, input int hx, input int hy);
    cur_en    = en;
    interlace = il;
    odd_start = odd;
    cur_x     = 11'(cx);
    cur_y     = 11'(cy);
    hot_x     = 5'(hx);
    hot_y     = 5'(hy);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    in_de = 1'b1; in_hsync = 1'b1; in_vsync = 1'b1; in_pixel = 24'hABCDEF;
    pix_x = '0; next_line = '0; field_odd = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_pixel == 24'h0, "R1", "reset out_pixel", int'(out_pixel), 0);
    chk({out_de, out_hsync, out_vsync} == 3'b000, "R1", "reset sync",
        int'({out_de, out_hsync, out_vsync}), 0);
    chk(mem_req == 1'b0, "R1", "reset mem_req", int'(mem_req), 0);
    in_de = 1'b0; in_hsync = 1'b0; in_vsync = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(out_pixel == 24'hABCDEF && !out_de, "R1", "first cycle after reset",
        int'(out_pixel), 24'hABCDEF);
  endtask

  // R3 R4 R6 R7: plain placement, bottom boundary at rows 63/64
  task automatic test_basic;
    set_cfg(1, 0, 0, 20, 5, 0, 0);
    run_line(3, 0, 1);
    for (int l = 4; l < 9; l++) run_line(l, 0, 0);
    for (int l = 66; l < 71; l++) run_line(l, 0, 0);
  endtask

  // R5 R6: hot-spot pushes the corner past the top and left edges
  task automatic test_hotspot_clip;
    set_cfg(1, 0, 0, 10, 2, 17, 9);
    for (int l = 0; l < 3; l++) run_line(l, 0, 0);
    for (int l = 55; l < 58; l++) run_line(l, 0, 0);
  endtask

  // R5: box runs past the right end of the active line
  task automatic test_right_edge;
    set_cfg(1, 0, 0, 70, 40, 3, 31);
    run_line(8, 0, 0);
    run_line(9, 0, 0);
    run_line(72, 0, 0);
    run_line(73, 0, 0);
  endtask

  // R8: disabled cursor issues no reads and leaves pixels alone
  task automatic test_disable;
    set_cfg(0, 0, 0, 20, 5, 0, 0);
    for (int l = 5; l < 8; l++) run_line(l, 0, 0);
  endtask

  // R9 R10: both fields, both start parities; blank x=0 lies inside the box
  task automatic test_interlace;
    set_cfg(1, 1, 1, 0, 3, 0, 0);
    run_line(3, 0, 0); run_line(4, 0, 0); run_line(35, 0, 0);
    run_line(2, 1, 0); run_line(3, 1, 0); run_line(35, 1, 0);
    set_cfg(1, 1, 0, 0, 3, 0, 0);
    run_line(3, 0, 1); run_line(3, 1, 0); run_line(34, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    color0 = 24'h12F0A5;
    color1 = 24'hE01C3B;
    test_reset();
    test_basic();
    test_hotspot_clip();
    test_right_edge();
    test_disable();
    test_interlace();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule